// File: doc/BRIEF.md
# Memory Access Permission Filter

The filter sits in front of a memory port and rules on every request: it is given the request address, the privilege level of the software issuing it and the kind of access. It compares the address with a set of programmed windows. Each window has an enable, a base, a size and a policy word. From this it decides whether the access may proceed. The window settings arrive as plain inputs from configuration storage that is held elsewhere. Programming those windows and moving data are handled outside this block.

Windows may overlap. A mode bit selects how an overlap is settled. In first-window mode, the matching window with the smallest index decides alone. In unanimous mode, every matching window has to allow the access. Only a write marked as privileged can change the mode bit. A less trusted agent therefore cannot switch the rule to one that suits a window it placed over a protected range.

Each request gives a registered verdict one cycle later. The verdict is a grant or a fault, together with the index of the deciding window. The index is 3 when no window matched. On a fault, the kind and privilege level of the refused request are also reported, so that logging logic can record them.

Top module: `mem_perm_filter`

## Requirements
- R1: Policy bit 0 allows reads, bit 1 writes and bit 2 execution for non-privileged requests. Bits 3, 4 and 5 allow the same three kinds for privileged requests (`req_priv`=1). Bits above 5 have no effect. The kind codes are 0 read, 1 write and 2 execute. Kind code 3 is never allowed by any window.
- R2: Window i matches when it is enabled and base <= addr < base + size. The sum is formed one bit wider than the address, so a window may reach the top of the address space without wrapping. A window of size 0 matches nothing.
- R3: A request that matches no window is refused, with a deciding index of 3.
- R4: With mode 0 (first-window), the matching window with the lowest index alone decides the verdict and is reported as the deciding index.
- R5: With mode 1 (unanimous), a request is granted only if every matching window allows it. On a grant the index is the lowest matching window. On a fault it is the lowest matching window that refused.
- R6: The mode bit resets to 0. It changes only when `mode_wr_en` is high together with `mode_wr_priv`. A new value applies to requests presented from the next cycle onward. A write without the privileged flag leaves the mode unchanged.
- R7: A request presented with `req_valid` in cycle n gives `rsp_valid` in cycle n+1, with exactly one of `rsp_grant`/`rsp_fault` high. Without a request, `rsp_valid`, `rsp_grant` and `rsp_fault` are low and `rsp_region` is 3. Back-to-back requests give back-to-back verdicts.
- R8: On a fault, `flt_kind` and `flt_priv` carry the refused request's kind and privilege level. On a grant or when idle, both are 0.
- R9: While `rst_n` is low, all response outputs are 0, except `rsp_region`, which is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | ADDR_W (16) | Request address |
| req_priv | input | 1 | 1 = privileged software, 0 = non-privileged |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| mode_wr_en | input | 1 | Write strobe for the overlap-mode bit |
| mode_wr_val | input | 1 | New mode: 0 first-window, 1 unanimous |
| mode_wr_priv | input | 1 | The mode write comes from privileged software |
| rgn_en | input | NUM_RGN (3) | Per-window enable |
| rgn_base | input | NUM_RGN*ADDR_W | Window bases, window i at bits [i*ADDR_W +: ADDR_W] |
| rgn_size | input | NUM_RGN*ADDR_W | Window sizes, same packing |
| rgn_policy | input | NUM_RGN*POL_W | Policy words, window i at bits [i*POL_W +: POL_W] |
| rsp_valid | output | 1 | A verdict is presented |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_region | output | ID_W (2) | Deciding window, 3 when none |
| flt_kind | output | 2 | Kind of the refused request |
| flt_priv | output | 1 | Privilege level of the refused request |

## Verification
The bench aims at overlap addresses where the two modes reach different verdicts or name different windows. A resolver that ignores the mode, or that reports the first match instead of the first refusing window, gets the index or the grant wrong there. It probes the exact window edges and a window ending at the top of the address space. A comparator that wraps or is off by one would grant addresses outside a window or drop its last word. It also checks that an unprivileged mode write is ignored, that policy bits above 5 and the reserved kind grant nothing, and that fault details appear only on refusals. A flaw in any of these would let lower-trust software widen its own access.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_EXEC  = 2'd2,
      KIND_RSVD  = 2'd3
   } acc_kind_e;

   // permission bit positions inside a policy word
   localparam int unsigned PB_RD_USER = 0;
   localparam int unsigned PB_WR_USER = 1;
   localparam int unsigned PB_EX_USER = 2;
   localparam int unsigned PB_RD_SUP  = 3;
   localparam int unsigned PB_WR_SUP  = 4;
   localparam int unsigned PB_EX_SUP  = 5;
   localparam int unsigned PB_COUNT   = 6;

   typedef enum logic {
      RES_FIRST     = 1'b0,
      RES_UNANIMOUS = 1'b1
   } res_mode_e;

endpackage

// File: rtl/mpf_region_match.sv
module mpf_region_match #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] size,
   input  logic              en,
   output logic              hit
);
   localparam int unsigned EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] limit_ext;
   logic [EXT_W-1:0] addr_ext;
   logic             above_base;
   logic             below_limit;

   // one extra bit keeps a window touching the top of the space from wrapping
   assign limit_ext   = {1'b0, base} + {1'b0, size};
   assign addr_ext    = {1'b0, addr};
   assign above_base  = (addr >= base);
   assign below_limit = (addr_ext < limit_ext);
   assign hit         = en & above_base & below_limit;

endmodule

// File: rtl/mpf_perm_select.sv
module mpf_perm_select
   import mpf_pkg::*;
#(
   parameter int unsigned POL_W = 32
) (
   input  logic [POL_W-1:0] policy,
   input  logic             priv,
   input  acc_kind_e        kind,
   output logic             allow
);
   logic [2:0] user_bits;
   logic [2:0] sup_bits;
   logic [2:0] level_bits;

   assign user_bits  = {policy[PB_EX_USER], policy[PB_WR_USER], policy[PB_RD_USER]};
   assign sup_bits   = {policy[PB_EX_SUP],  policy[PB_WR_SUP],  policy[PB_RD_SUP]};
   assign level_bits = priv ? sup_bits : user_bits;

   always_comb begin
      unique case (kind)
         KIND_READ:  allow = level_bits[0];
         KIND_WRITE: allow = level_bits[1];
         KIND_EXEC:  allow = level_bits[2];
         default:    allow = 1'b0;
      endcase
   end

   generate
      if (POL_W > PB_COUNT) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^policy[POL_W-1:PB_COUNT];
      end
   endgenerate

endmodule

// File: rtl/mpf_resolve.sv
module mpf_resolve #(
   parameter int unsigned NUM_RGN      = 3,
   parameter int unsigned ID_W         = 2,
   parameter bit          HAS_ALL_MODE = 1'b1
) (
   input  logic [NUM_RGN-1:0] hit,
   input  logic [NUM_RGN-1:0] allow,
   input  logic               all_mode,
   output logic               grant,
   output logic [ID_W-1:0]    win_id
);
   localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

   logic [NUM_RGN-1:0] refuse_vec;
   logic [ID_W-1:0]    first_hit;
   logic [ID_W-1:0]    first_refuse;
   logic               any_hit;
   logic               any_refuse;
   logic               first_grant;
   logic [ID_W-1:0]    first_id;

   assign refuse_vec = hit & ~allow;
   assign any_hit    = |hit;
   assign any_refuse = |refuse_vec;

   // scan from the top so the lowest index is left standing
   always_comb begin
      first_hit    = NONE_ID;
      first_refuse = NONE_ID;
      for (int i = NUM_RGN - 1; i >= 0; i--) begin
         if (hit[i])        first_hit    = ID_W'(i);
         if (refuse_vec[i]) first_refuse = ID_W'(i);
      end
   end

   always_comb begin
      first_grant = 1'b0;
      for (int i = NUM_RGN - 1; i >= 0; i--) begin
         if (hit[i]) first_grant = allow[i];
      end
      first_id = first_hit;
   end

   generate
      if (HAS_ALL_MODE) begin : g_both
         logic all_grant;
         logic [ID_W-1:0] all_id;
         assign all_grant = any_hit & ~any_refuse;
         assign all_id    = any_refuse ? first_refuse : first_hit;
         assign grant     = all_mode ? all_grant : first_grant;
         assign win_id    = all_mode ? all_id    : first_id;
      end else begin : g_first_only
         logic unused_mode;
         assign unused_mode = all_mode ^ any_refuse ^ (^first_refuse);
         assign grant       = first_grant;
         assign win_id      = first_id;
      end
   endgenerate

endmodule

// File: rtl/mem_perm_filter.sv
module mem_perm_filter
   import mpf_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned NUM_RGN      = 3,
   parameter int unsigned POL_W        = 32,
   parameter bit          HAS_ALL_MODE = 1'b1,
   parameter int unsigned ID_W         = $clog2(NUM_RGN + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic                       req_priv,
   input  logic [1:0]                 req_kind,
   input  logic                       mode_wr_en,
   input  logic                       mode_wr_val,
   input  logic                       mode_wr_priv,
   input  logic [NUM_RGN-1:0]         rgn_en,
   input  logic [NUM_RGN*ADDR_W-1:0]  rgn_base,
   input  logic [NUM_RGN*ADDR_W-1:0]  rgn_size,
   input  logic [NUM_RGN*POL_W-1:0]   rgn_policy,
   output logic                       rsp_valid,
   output logic                       rsp_grant,
   output logic                       rsp_fault,
   output logic [ID_W-1:0]            rsp_region,
   output logic [1:0]                 flt_kind,
   output logic                       flt_priv
);
   localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mem_perm_filter: ADDR_W must be at least 2");
      end
      if (NUM_RGN < 1) begin : g_bad_rgn
         $error("mem_perm_filter: NUM_RGN must be at least 1");
      end
      if ((2 ** ID_W) - 1 < NUM_RGN) begin : g_bad_id
         $error("mem_perm_filter: ID_W too narrow to keep a no-match code");
      end
      if (POL_W < PB_COUNT) begin : g_bad_pol
         $error("mem_perm_filter: POL_W must hold all permission bits");
      end
   endgenerate

   logic               mode_q;
   logic [NUM_RGN-1:0] hit;
   logic [NUM_RGN-1:0] allow;
   logic               grant_d;
   logic [ID_W-1:0]    win_d;
   acc_kind_e          kind;

   assign kind = acc_kind_e'(req_kind);

   // overlap mode bit, writable by privileged software only
   generate
      if (HAS_ALL_MODE) begin : g_mode_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mode_q <= RES_FIRST;
            end else if (mode_wr_en && mode_wr_priv) begin
               mode_q <= mode_wr_val;
            end
         end
      end else begin : g_mode_fixed
         logic unused_mode_wr;
         assign unused_mode_wr = mode_wr_en ^ mode_wr_val ^ mode_wr_priv;
         assign mode_q         = RES_FIRST;
      end
   endgenerate

   // one comparator and one policy selector per window
   generate
      for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
         mpf_region_match #(
            .ADDR_W (ADDR_W)
         ) i_match (
            .addr (req_addr),
            .base (rgn_base[g*ADDR_W +: ADDR_W]),
            .size (rgn_size[g*ADDR_W +: ADDR_W]),
            .en   (rgn_en[g]),
            .hit  (hit[g])
         );

         mpf_perm_select #(
            .POL_W (POL_W)
         ) i_perm (
            .policy (rgn_policy[g*POL_W +: POL_W]),
            .priv   (req_priv),
            .kind   (kind),
            .allow  (allow[g])
         );
      end
   endgenerate

   mpf_resolve #(
      .NUM_RGN      (NUM_RGN),
      .ID_W         (ID_W),
      .HAS_ALL_MODE (HAS_ALL_MODE)
   ) i_resolve (
      .hit      (hit),
      .allow    (allow),
      .all_mode (mode_q),
      .grant    (grant_d),
      .win_id   (win_d)
   );

   // registered verdict
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_grant  <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_region <= NONE_ID;
         flt_kind   <= 2'd0;
         flt_priv   <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_grant  <= req_valid & grant_d;
         rsp_fault  <= req_valid & ~grant_d;
         rsp_region <= req_valid ? win_d : NONE_ID;
         flt_kind   <= (req_valid && !grant_d) ? req_kind : 2'd0;
         flt_priv   <= req_valid & ~grant_d & req_priv;
      end
   end

endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
   parameter int unsigned ID_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_priv,
   input logic [1:0]      req_kind,
   input logic            mode_wr_en,
   input logic            mode_wr_priv,
   input logic            mode_q,
   input logic            rsp_valid,
   input logic            rsp_grant,
   input logic            rsp_fault,
   input logic [ID_W-1:0] rsp_region,
   input logic [1:0]      flt_kind,
   input logic            flt_priv
);
   localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_grant, rsp_fault}) == 1)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_grant && !rsp_fault && rsp_region == NONE_ID)); // R7

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R7

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R7

   AST_NOMATCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_region == NONE_ID) |-> rsp_fault); // R3

   AST_FAULT_INFO: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_fault |-> (flt_kind == $past(req_kind) && flt_priv == $past(req_priv)))); // R8

   AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_fault |-> (flt_kind == 2'd0 && !flt_priv)); // R8

   AST_MODE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_wr_en && mode_wr_priv) |=> $stable(mode_q)); // R6

endmodule

bind mem_perm_filter mpf_checker #(
   .ID_W (ID_W)
) i_mpf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_priv     (req_priv),
   .req_kind     (req_kind),
   .mode_wr_en   (mode_wr_en),
   .mode_wr_priv (mode_wr_priv),
   .mode_q       (mode_q),
   .rsp_valid    (rsp_valid),
   .rsp_grant    (rsp_grant),
   .rsp_fault    (rsp_fault),
   .rsp_region   (rsp_region),
   .flt_kind     (flt_kind),
   .flt_priv     (flt_priv)
);

// File: tb/test_mem_perm_filter.sv
`timescale 1ns/1ps
module test_mem_perm_filter;
   localparam int unsigned ADDR_W  = 16;
   localparam int unsigned NUM_RGN = 3;
   localparam int unsigned POL_W   = 32;
   localparam int unsigned ID_W    = 2;
   localparam int unsigned NVEC    = 18;

   logic                      clk = 1'b0;
   logic                      rst_n;
   logic                      req_valid;
   logic [ADDR_W-1:0]         req_addr;
   logic                      req_priv;
   logic [1:0]                req_kind;
   logic                      mode_wr_en, mode_wr_val, mode_wr_priv;
   logic [NUM_RGN-1:0]        rgn_en;
   logic [NUM_RGN*ADDR_W-1:0] rgn_base;
   logic [NUM_RGN*ADDR_W-1:0] rgn_size;
   logic [NUM_RGN*POL_W-1:0]  rgn_policy;
   logic                      rsp_valid, rsp_grant, rsp_fault;
   logic [ID_W-1:0]           rsp_region;
   logic [1:0]                flt_kind;
   logic                      flt_priv;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   mem_perm_filter i_mem_perm_filter (
      .clk, .rst_n, .req_valid, .req_addr, .req_priv, .req_kind,
      .mode_wr_en, .mode_wr_val, .mode_wr_priv,
      .rgn_en, .rgn_base, .rgn_size, .rgn_policy,
      .rsp_valid, .rsp_grant, .rsp_fault, .rsp_region, .flt_kind, .flt_priv
   );

   // {mode, addr[15:0], priv, kind[1:0], exp_grant, exp_id[1:0]}
   // windows: W0 1000..1FFF policy 0x38, W1 1800..27FF policy 0x19,
   //          W2 2000..3FFF policy 0xFFFFFF0F
   localparam logic [22:0] VEC [NVEC] = '{
      {1'b0, 16'h1000, 1'b1, 2'd0, 1'b1, 2'd0},
      {1'b0, 16'h1000, 1'b0, 2'd0, 1'b0, 2'd0},
      {1'b0, 16'h0FFF, 1'b0, 2'd0, 1'b0, 2'd3},
      {1'b0, 16'h1FFF, 1'b1, 2'd1, 1'b1, 2'd0},
      {1'b0, 16'h1900, 1'b0, 2'd0, 1'b0, 2'd0},
      {1'b1, 16'h1900, 1'b0, 2'd0, 1'b0, 2'd0},
      {1'b0, 16'h2000, 1'b0, 2'd0, 1'b1, 2'd1},
      {1'b1, 16'h2000, 1'b0, 2'd0, 1'b1, 2'd1},
      {1'b0, 16'h2000, 1'b0, 2'd1, 1'b0, 2'd1},
      {1'b0, 16'h2000, 1'b1, 2'd1, 1'b1, 2'd1},
      {1'b1, 16'h2000, 1'b1, 2'd1, 1'b0, 2'd2},
      {1'b0, 16'h2800, 1'b0, 2'd2, 1'b1, 2'd2},
      {1'b0, 16'h2800, 1'b1, 2'd2, 1'b0, 2'd2},
      {1'b1, 16'h3FFF, 1'b0, 2'd1, 1'b1, 2'd2},
      {1'b1, 16'h4000, 1'b0, 2'd1, 1'b0, 2'd3},
      {1'b0, 16'h1800, 1'b1, 2'd2, 1'b1, 2'd0},
      {1'b1, 16'h1800, 1'b1, 2'd2, 1'b0, 2'd1},
      {1'b1, 16'h2800, 1'b0, 2'd3, 1'b0, 2'd2}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_win(input int w, input logic [15:0] b, input logic [15:0] s,
                          input logic [31:0] p);
      rgn_base[w*ADDR_W +: ADDR_W]  = b;
      rgn_size[w*ADDR_W +: ADDR_W]  = s;
      rgn_policy[w*POL_W +: POL_W]  = p;
   endtask

   task automatic default_wins();
      rgn_en = 3'b111;
      set_win(0, 16'h1000, 16'h1000, 32'h0000_0038);
      set_win(1, 16'h1800, 16'h1000, 32'h0000_0019);
      set_win(2, 16'h2000, 16'h2000, 32'hFFFF_FF0F);
   endtask

   task automatic write_mode(input logic val, input logic priv);
      @(negedge clk);
      mode_wr_en = 1'b1; mode_wr_val = val; mode_wr_priv = priv;
      @(negedge clk);
      mode_wr_en = 1'b0; mode_wr_priv = 1'b0;
   endtask

   // drive at a falling edge, sample 1 ns after the next rising edge
   task automatic send(input logic [15:0] a, input logic p, input logic [1:0] k);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_priv = p; req_kind = k;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string req, input logic g, input logic [1:0] id,
                             input logic p, input logic [1:0] k);
      chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
      chk(req, "rsp_grant", 32'(rsp_grant), 32'(g));
      chk(req, "rsp_fault", 32'(rsp_fault), 32'(!g));
      chk(req, "rsp_region", 32'(rsp_region), 32'(id));
      chk("R8", "flt_kind", 32'(flt_kind), g ? 32'd0 : 32'(k));
      chk("R8", "flt_priv", 32'(flt_priv), g ? 32'd0 : 32'(p));
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_priv = 1'b0; req_kind = 2'd0;
      mode_wr_en = 1'b0; mode_wr_val = 1'b0; mode_wr_priv = 1'b0;
      rgn_base = '0; rgn_size = '0; rgn_policy = '0; rgn_en = '0;
      default_wins();
      repeat (3) @(negedge clk);
      // R9 reset values
      chk("R9", "rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R9", "rsp_grant", 32'(rsp_grant), 32'd0);
      chk("R9", "rsp_fault", 32'(rsp_fault), 32'd0);
      chk("R9", "rsp_region", 32'(rsp_region), 32'd3);
      chk("R9", "flt", 32'({flt_kind, flt_priv}), 32'd0);
      rst_n = 1'b1;

      // vector table (R1 R2 R3 R4 R5)
      for (int v = 0; v < NVEC; v++) begin
         logic [22:0] e;
         e = VEC[v];
         write_mode(e[22], 1'b1);
         send(e[21:6], e[5], e[4:3]);
         expect_rsp(e[22] ? "R5 vec" : "R4 vec", e[2], e[1:0], e[5], e[4:3]);
      end

      // R7 idle after a request
      @(posedge clk); #1;
      chk("R7", "idle rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R7", "idle rsp_region", 32'(rsp_region), 32'd3);

      // R6 unprivileged mode write ignored: mode stays unanimous
      write_mode(1'b1, 1'b1);
      write_mode(1'b0, 1'b0);
      send(16'h2000, 1'b1, 2'd1);
      expect_rsp("R6 ignored write", 1'b0, 2'd2, 1'b1, 2'd1);
      write_mode(1'b0, 1'b1);
      send(16'h2000, 1'b1, 2'd1);
      expect_rsp("R6 privileged write", 1'b1, 2'd1, 1'b1, 2'd1);

      // R2 disabled window and zero-size window
      @(negedge clk); rgn_en[0] = 1'b0;
      send(16'h1000, 1'b1, 2'd0);
      expect_rsp("R2 disabled", 1'b0, 2'd3, 1'b1, 2'd0);
      @(negedge clk); default_wins(); set_win(2, 16'h2000, 16'h0000, 32'hFFFF_FF0F);
      send(16'h2800, 1'b0, 2'd2);
      expect_rsp("R2 size zero", 1'b0, 2'd3, 1'b0, 2'd2);

      // R2 window ending at the top of the address space
      @(negedge clk); set_win(2, 16'hF000, 16'h1000, 32'h0000_0001);
      send(16'hFFFF, 1'b0, 2'd0);
      expect_rsp("R2 top edge", 1'b1, 2'd2, 1'b0, 2'd0);
      send(16'h0005, 1'b0, 2'd0);
      expect_rsp("R2 no wrap", 1'b0, 2'd3, 1'b0, 2'd0);
      @(negedge clk); default_wins();

      // R1 upper policy bits grant nothing
      @(negedge clk); set_win(2, 16'h2000, 16'h2000, 32'hFFFF_FFC0);
      send(16'h3000, 1'b0, 2'd0);
      expect_rsp("R1 high bits", 1'b0, 2'd2, 1'b0, 2'd0);
      @(negedge clk); default_wins();

      // R7 back-to-back requests
      @(negedge clk);
      req_valid = 1'b1; req_addr = 16'h1000; req_priv = 1'b1; req_kind = 2'd0;
      @(negedge clk);
      chk("R7", "b2b first grant", 32'(rsp_grant), 32'd1);
      req_addr = 16'h0100; req_priv = 1'b0; req_kind = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7", "b2b second fault", 32'(rsp_fault), 32'd1);
      chk("R8", "b2b flt_kind", 32'(flt_kind), 32'd1);
      chk("R3", "b2b region", 32'(rsp_region), 32'd3);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule